// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows one processor core through its power states: running (Normal), halted (HALT), deep halt with the sequencer lowering frequency and voltage (Extended HALT), clock-stopped (Stop-Grant), and a snoop-service state that can be entered from any of the idle states. It keeps the state register and the decisions between states. Clock gating, bus signalling and the actual ratio and voltage moves are done elsewhere. The controller asks an external frequency/voltage sequencer to lower or raise the operating point and waits for that sequencer's done strobe.

While the clock is stopped, interrupt-class events (SMI, INIT and the local interrupt lines) are collected in sticky flags, one flag per event. These flags are shown to the core only when it is back in Normal. Entry into Stop-Grant is timed from the bus response to the stop-grant acknowledge cycle. It takes a fixed number of bus clocks, set by a parameter whose default is 20.

Top module: `pwr_state_ctl`

## Requirements
- R1: Synchronous reset `rst` puts the block in Normal and clears every output and every pending flag. The state codes on `state_o` are: 0 Normal, 1 HALT, 2 Extended HALT, 3 Stop-Grant, 4 snoop service, 5 entering Extended HALT, 6 leaving Extended HALT, 7 waiting for Stop-Grant.
- R2: In Normal, a `halt_req_i` pulse goes to HALT (code 1) when `xhalt_en_i` and `all_halt_i` are not both high. In HALT, a `brk_i` strobe or any bit of `evt_i` returns the block to Normal on the next clock.
- R3: In Normal, a `halt_req_i` pulse with both `xhalt_en_i` and `all_halt_i` high goes to code 5 with `seq_lower_o` high. The block stays in code 5 until `seq_done_i`, and then moves to Extended HALT (code 2).
- R4: In Extended HALT, `brk_i` goes to code 6 with `seq_raise_o` high. The block stays in code 6 until `seq_done_i`, and then returns to Normal.
- R5: A low level on `stpclk_n_i` in Normal or HALT goes to code 7. Stop-Grant (code 3) is entered exactly SG_DELAY clocks after the clock edge that samples `sg_rsp_i` high. `clk_stop_o` is high exactly while the state is Stop-Grant.
- R6: When `stpclk_n_i` goes high in Stop-Grant or in code 7, the block returns to the state it came from: HALT if the stop request arrived in HALT, otherwise Normal.
- R7: `core_init_i` in Stop-Grant leaves the state unchanged. In any other state it forces Normal. In every case it gives a one-clock `init_pulse_o` on the following clock.
- R8: `snoop_hit_i` in HALT, Extended HALT or Stop-Grant goes to snoop service (code 4). `snoop_done_i` then returns the block to the state it came from.
- R9: Each bit of `evt_i` (bit 0 SMI, bit 1 INIT, bits 2 and up local interrupts) sets its own sticky flag, and repeated pulses count as one. `pend_o` shows the flags only while the state is Normal. A set `evt_ack_i` bit clears its flag only in Normal. Events in Stop-Grant do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | Halt request pulse from the core |
| all_halt_i | input | 1 | High when every core has requested halt |
| xhalt_en_i | input | 1 | Enable for Extended HALT |
| stpclk_n_i | input | 1 | Active-low stop-clock request |
| sg_rsp_i | input | 1 | Response strobe of the stop-grant acknowledge cycle |
| snoop_hit_i | input | 1 | Snoop detected |
| snoop_done_i | input | 1 | Snoop serviced |
| core_init_i | input | 1 | Core reset/initialise request |
| brk_i | input | 1 | Break event strobe |
| seq_done_i | input | 1 | Frequency/voltage sequencer done |
| evt_i | input | N_EVT | Event strobes: SMI, INIT, local interrupts |
| evt_ack_i | input | N_EVT | Service acknowledge per event |
| state_o | output | 3 | Current state code |
| clk_stop_o | output | 1 | Core clock is stopped |
| seq_lower_o | output | 1 | Request lower operating point |
| seq_raise_o | output | 1 | Request original operating point |
| init_pulse_o | output | 1 | Initialisation pulse |
| pend_o | output | N_EVT | Pending events presented for service |

## Verification
The assertions check four behaviours on every clock: the sequencer waits hold, an initialise request in Stop-Grant does not change the state, a snoop-service exit leaves the snoop state, and a pending flag can only be cleared by an acknowledge. They also check that Stop-Grant is never entered before the delay counter runs out. The exact delay of SG_DELAY clocks, the return to the correct origin state after stop-clock release or a snoop, and the collapse of repeated events into a single pending flag can only be shown by the bench's scenarios. The bench compares against its cycle model on every clock.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_HALT     = 3'd1,
    ST_XHALT    = 3'd2,
    ST_STOPG    = 3'd3,
    ST_SNOOP    = 3'd4,
    ST_XH_ENTER = 3'd5,
    ST_XH_EXIT  = 3'd6,
    ST_SG_WAIT  = 3'd7
  } pwr_state_e;

  localparam int EVT_SMI  = 0;
  localparam int EVT_INIT = 1;
  localparam int EVT_LINT = 2;
endpackage

// File: rtl/pwr_sg_timer.sv
module pwr_sg_timer #(
  parameter int SG_DELAY = 20,
  localparam int CW = $clog2(SG_DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic rsp,
  output logic fire
);
  logic          armed_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q && rsp) begin
      armed_q <= 1'b1;
      cnt_q   <= CW'(SG_DELAY - 1);
    end else if (armed_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire = run && armed_q && (cnt_q == '0);

  // R5: counting stays inside the window while armed
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (cnt_q <= CW'(SG_DELAY - 1)));
endmodule

// File: rtl/pwr_evt_latch.sv
module pwr_evt_latch #(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_normal,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] ack,
  output logic [N_EVT-1:0] pend
);
  logic [N_EVT-1:0] hold_q;
  logic [N_EVT-1:0] clr;

  assign clr = ack & {N_EVT{in_normal}};

  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         hold_q[i] <= 1'b0;
      else if (evt[i]) hold_q[i] <= 1'b1;
      else if (clr[i]) hold_q[i] <= 1'b0;
    end

    // R9: a flag survives until acknowledged in Normal
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (hold_q[i] && !clr[i]) |=> hold_q[i]);
  end

  assign pend = hold_q & {N_EVT{in_normal}};
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req,
  input  logic       all_halt,
  input  logic       xhalt_en,
  input  logic       stpclk_n,
  input  logic       snoop_hit,
  input  logic       snoop_done,
  input  logic       core_init,
  input  logic       brk,
  input  logic       seq_done,
  input  logic       evt_any,
  input  logic       sg_fire,
  output pwr_state_e state_q,
  output logic       sg_run,
  output logic       clk_stop_q,
  output logic       seq_lower_q,
  output logic       seq_raise_q,
  output logic       init_pulse_q
);
  pwr_state_e st_n, snp_ret_q, snp_ret_n, sg_ret_q, sg_ret_n;

  always_comb begin
    st_n      = state_q;
    snp_ret_n = snp_ret_q;
    sg_ret_n  = sg_ret_q;
    if (core_init && state_q != ST_STOPG) begin
      st_n = ST_NORMAL;
    end else begin
      unique case (state_q)
        ST_NORMAL: begin
          if (!stpclk_n) begin
            st_n     = ST_SG_WAIT;
            sg_ret_n = ST_NORMAL;
          end else if (halt_req) begin
            st_n = (xhalt_en && all_halt) ? ST_XH_ENTER : ST_HALT;
          end
        end
        ST_HALT: begin
          if (!stpclk_n) begin
            st_n     = ST_SG_WAIT;
            sg_ret_n = ST_HALT;
          end else if (snoop_hit) begin
            st_n      = ST_SNOOP;
            snp_ret_n = ST_HALT;
          end else if (brk || evt_any) begin
            st_n = ST_NORMAL;
          end
        end
        ST_XH_ENTER: if (seq_done) st_n = ST_XHALT;
        ST_XHALT: begin
          if (snoop_hit) begin
            st_n      = ST_SNOOP;
            snp_ret_n = ST_XHALT;
          end else if (brk) begin
            st_n = ST_XH_EXIT;
          end
        end
        ST_XH_EXIT: if (seq_done) st_n = ST_NORMAL;
        ST_SG_WAIT: begin
          if (stpclk_n)     st_n = sg_ret_q;
          else if (sg_fire) st_n = ST_STOPG;
        end
        ST_STOPG: begin
          if (stpclk_n) begin
            st_n = sg_ret_q;
          end else if (snoop_hit) begin
            st_n      = ST_SNOOP;
            snp_ret_n = ST_STOPG;
          end
        end
        ST_SNOOP: if (snoop_done) st_n = snp_ret_q;
        default: st_n = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_NORMAL;
      snp_ret_q    <= ST_NORMAL;
      sg_ret_q     <= ST_NORMAL;
      clk_stop_q   <= 1'b0;
      seq_lower_q  <= 1'b0;
      seq_raise_q  <= 1'b0;
      init_pulse_q <= 1'b0;
    end else begin
      state_q      <= st_n;
      snp_ret_q    <= snp_ret_n;
      sg_ret_q     <= sg_ret_n;
      clk_stop_q   <= (st_n == ST_STOPG);
      seq_lower_q  <= (st_n == ST_XH_ENTER);
      seq_raise_q  <= (st_n == ST_XH_EXIT);
      init_pulse_q <= core_init;
    end
  end

  assign sg_run = (state_q == ST_SG_WAIT);

  // R3: sequencer wait on entry holds until done
  assert_xh_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XH_ENTER && !seq_done && !core_init) |=> state_q == ST_XH_ENTER);
  // R4: sequencer wait on exit holds until done
  assert_xh_exit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XH_EXIT && !seq_done && !core_init) |=> state_q == ST_XH_EXIT);
  // R2: break wakes HALT on the next clock
  assert_halt_wake_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && brk && stpclk_n && !snoop_hit && !core_init) |=> state_q == ST_NORMAL);
  // R7: init in Stop-Grant keeps the state and pulses
  assert_init_stay_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOPG && core_init && !stpclk_n && !snoop_hit) |=> (state_q == ST_STOPG && init_pulse_q));
  // R8: snoop service ends on done
  assert_snoop_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SNOOP && snoop_done && !core_init) |=> state_q != ST_SNOOP);
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_pkg::*;
#(
  parameter int SG_DELAY = 20,
  parameter int N_LINT   = 2,
  localparam int N_EVT   = EVT_LINT + N_LINT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req_i,
  input  logic             all_halt_i,
  input  logic             xhalt_en_i,
  input  logic             stpclk_n_i,
  input  logic             sg_rsp_i,
  input  logic             snoop_hit_i,
  input  logic             snoop_done_i,
  input  logic             core_init_i,
  input  logic             brk_i,
  input  logic             seq_done_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] evt_ack_i,
  output logic [2:0]       state_o,
  output logic             clk_stop_o,
  output logic             seq_lower_o,
  output logic             seq_raise_o,
  output logic             init_pulse_o,
  output logic [N_EVT-1:0] pend_o
);
  pwr_state_e state;
  logic       sg_run, sg_fire;

  pwr_sg_timer #(.SG_DELAY(SG_DELAY)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (sg_run),
    .rsp (sg_rsp_i),
    .fire(sg_fire)
  );

  pwr_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .halt_req    (halt_req_i),
    .all_halt    (all_halt_i),
    .xhalt_en    (xhalt_en_i),
    .stpclk_n    (stpclk_n_i),
    .snoop_hit   (snoop_hit_i),
    .snoop_done  (snoop_done_i),
    .core_init   (core_init_i),
    .brk         (brk_i),
    .seq_done    (seq_done_i),
    .evt_any     (|evt_i),
    .sg_fire     (sg_fire),
    .state_q     (state),
    .sg_run      (sg_run),
    .clk_stop_q  (clk_stop_o),
    .seq_lower_q (seq_lower_o),
    .seq_raise_q (seq_raise_o),
    .init_pulse_q(init_pulse_o)
  );

  pwr_evt_latch #(.N_EVT(N_EVT)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .in_normal(state == ST_NORMAL),
    .evt      (evt_i),
    .ack      (evt_ack_i),
    .pend     (pend_o)
  );

  assign state_o = state;

  // R5: no Stop-Grant before the delay counter expires
  assert_sg_early_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SG_WAIT && !sg_fire) |=> state != ST_STOPG);
  // R5: clock-stop flag tracks the Stop-Grant state
  assert_clk_stop_R5: assert property (@(posedge clk) disable iff (rst)
    clk_stop_o == (state == ST_STOPG));
endmodule

// File: tb/pwr_state_ctl_tb_top.sv
`timescale 1ns/100ps
module pwr_state_ctl_tb_top;
  localparam int SG = 20;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, all_halt = 0, xen = 0, stpclk_n = 1, rsp = 0;
  logic snp = 0, snp_done = 0, cinit = 0, brk = 0, sdone = 0;
  logic [NE-1:0] evt = '0, ack = '0;
  logic [2:0] state_o;
  logic clk_stop, s_lower, s_raise, initp;
  logic [NE-1:0] pend;

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwr_state_ctl #(.SG_DELAY(SG), .N_LINT(2)) dut_i (
    .clk(clk), .rst(rst), .halt_req_i(halt_req), .all_halt_i(all_halt),
    .xhalt_en_i(xen), .stpclk_n_i(stpclk_n), .sg_rsp_i(rsp),
    .snoop_hit_i(snp), .snoop_done_i(snp_done), .core_init_i(cinit),
    .brk_i(brk), .seq_done_i(sdone), .evt_i(evt), .evt_ack_i(ack),
    .state_o(state_o), .clk_stop_o(clk_stop), .seq_lower_o(s_lower),
    .seq_raise_o(s_raise), .init_pulse_o(initp), .pend_o(pend));

  // Behavioural reference model
  int m_st = 0, m_sg = 0, m_sn = 0, m_cnt = 0;
  bit m_arm = 0, m_ip = 0;
  logic [NE-1:0] m_hold = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_sg = 0; m_sn = 0; m_cnt = 0; m_arm = 0; m_ip = 0; m_hold = '0;
    end else begin
      int nst;
      bit fire;
      logic [NE-1:0] clr;
      nst = m_st;
      fire = (m_st == 7) && m_arm && (m_cnt == 0);
      clr = (m_st == 0) ? ack : '0;
      if (cinit && m_st != 3) nst = 0;
      else case (m_st)
        0: if (!stpclk_n) begin nst = 7; m_sg = 0; end
           else if (halt_req) nst = (xen && all_halt) ? 5 : 1;
        1: if (!stpclk_n) begin nst = 7; m_sg = 1; end
           else if (snp) begin nst = 4; m_sn = 1; end
           else if (brk || evt != 0) nst = 0;
        5: if (sdone) nst = 2;
        2: if (snp) begin nst = 4; m_sn = 2; end else if (brk) nst = 6;
        6: if (sdone) nst = 0;
        7: if (stpclk_n) nst = m_sg; else if (fire) nst = 3;
        3: if (stpclk_n) nst = m_sg; else if (snp) begin nst = 4; m_sn = 3; end
        4: if (snp_done) nst = m_sn;
        default: nst = 0;
      endcase
      if (m_st != 7) begin m_arm = 0; m_cnt = 0; end
      else if (!m_arm && rsp) begin m_arm = 1; m_cnt = SG - 1; end
      else if (m_arm && m_cnt != 0) m_cnt = m_cnt - 1;
      m_hold = (m_hold & ~clr) | evt;
      m_ip = cinit;
      m_st = nst;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk({cur_req, " state"}, state_o, m_st);
      chk({cur_req, " clk_stop"}, clk_stop, m_st == 3);
      chk({cur_req, " seq_lower"}, s_lower, m_st == 5);
      chk({cur_req, " seq_raise"}, s_raise, m_st == 6);
      chk({cur_req, " init_pulse"}, initp, m_ip);
      chk({cur_req, " pend"}, pend, (m_st == 0) ? m_hold : 0);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sg_enter();
    stpclk_n = 0; tick(1);
    tick(3);
    rsp = 1; tick(1); rsp = 0;
    tick(SG - 1);
    chk("R5 before expiry", state_o, 7);
    tick(1);
    chk("R5 enter Stop-Grant", state_o, 3);
    chk("R5 clk_stop", clk_stop, 1);
  endtask

  initial begin
    tick(3);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset outputs", {clk_stop, s_lower, s_raise, initp, pend}, 0);
    rst = 0;
    tick(1);

    cur_req = "R2";
    halt_req = 1; tick(1); halt_req = 0;
    chk("R2 halt", state_o, 1);
    tick(2);
    brk = 1; tick(1); brk = 0;
    chk("R2 break wake", state_o, 0);
    halt_req = 1; tick(1); halt_req = 0;
    evt[0] = 1; tick(1); evt[0] = 0;
    chk("R2 event wake", state_o, 0);
    chk("R9 smi shown", pend, 4'b0001);
    ack = 4'b0001; tick(1); ack = 0;
    chk("R9 ack clears", pend, 0);

    cur_req = "R3";
    xen = 1; all_halt = 1;
    halt_req = 1; tick(1); halt_req = 0;
    chk("R3 xh enter", state_o, 5);
    chk("R3 seq_lower", s_lower, 1);
    tick(3);
    chk("R3 wait done", state_o, 5);
    sdone = 1; tick(1); sdone = 0;
    chk("R3 xhalt", state_o, 2);

    cur_req = "R8";
    snp = 1; tick(1); snp = 0;
    chk("R8 snoop from xhalt", state_o, 4);
    tick(2);
    snp_done = 1; tick(1); snp_done = 0;
    chk("R8 back to xhalt", state_o, 2);

    cur_req = "R4";
    brk = 1; tick(1); brk = 0;
    chk("R4 xh exit", state_o, 6);
    chk("R4 seq_raise", s_raise, 1);
    tick(2);
    chk("R4 wait done", state_o, 6);
    sdone = 1; tick(1); sdone = 0;
    chk("R4 normal", state_o, 0);
    xen = 0; all_halt = 0;

    cur_req = "R5";
    sg_enter();

    cur_req = "R9";
    evt[1] = 1; tick(1); evt[1] = 0;
    evt[2] = 1; tick(1); evt[2] = 0;
    evt[2] = 1; tick(1); evt[2] = 0;
    chk("R9 no wake in stop", state_o, 3);
    chk("R9 hidden in stop", pend, 0);

    cur_req = "R7";
    cinit = 1; tick(1); cinit = 0;
    chk("R7 stays stop", state_o, 3);
    chk("R7 init pulse", initp, 1);

    cur_req = "R8";
    snp = 1; tick(1); snp = 0;
    chk("R8 snoop from stop", state_o, 4);
    snp_done = 1; tick(1); snp_done = 0;
    chk("R8 back to stop", state_o, 3);

    cur_req = "R6";
    stpclk_n = 1; tick(1);
    chk("R6 release to normal", state_o, 0);
    chk("R9 collapsed pending", pend, 4'b0110);
    ack = 4'b0110; tick(1); ack = 0;

    halt_req = 1; tick(1); halt_req = 0;
    cur_req = "R5";
    sg_enter();
    cur_req = "R6";
    stpclk_n = 1; tick(1);
    chk("R6 release to halt", state_o, 1);
    brk = 1; tick(1); brk = 0;

    stpclk_n = 0; tick(1);
    chk("R6 waiting", state_o, 7);
    stpclk_n = 1; tick(1);
    chk("R6 abort", state_o, 0);

    cur_req = "R7";
    halt_req = 1; tick(1); halt_req = 0;
    cinit = 1; tick(1); cinit = 0;
    chk("R7 init from halt", state_o, 0);

    cur_req = "R8";
    halt_req = 1; tick(1); halt_req = 0;
    snp = 1; tick(1); snp = 0;
    snp_done = 1; tick(1); snp_done = 0;
    chk("R8 back to halt", state_o, 1);
    brk = 1; tick(1); brk = 0;
    tick(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule